// File: doc/BRIEF.md
# General-Purpose I/O Port with Peripheral Overrides

This block is one general-purpose I/O port of `NPIN` pins, modelled at register and gate level. Each pin holds a direction bit and an output-value bit. Both are loaded from a shared write-data bus through port-wide write strobes and returned on a shared read-data bus through port-wide read strobes. A third write strobe flips output-value bits selectively, so software needs no read-modify-write.

Peripheral modules can take over a pin, each control on its own, without changing the software-visible registers. Per-pin enable/value override pairs exist for:
- the pull-up,
- the output-driver enable,
- the driven value,
- the digital-input enable.

A further per-pin override inverts the stored output-value bit on every clock edge where it is set.

The pad input is gated by the input enable. That gated bit goes to peripherals unsynchronized. It also passes through a two-stage synchronizer: a falling-edge stage, then a rising-edge stage. The synchronizer output forms the pin register that software reads. A global pull-up-disable input and a global sleep input act on every pin.

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted, the direction, output-value and pin registers read 0. With no override active, `pad_oe` and `pad_pu` are 0.
- R2: On a rising clock edge with `wr_dir` or `wr_port` high, the direction or output-value register loads `wdata`. `rdata` is the bitwise OR of the direction register (if `rd_dir` is high), the output-value register (if `rd_port` is high) and the pin register (if `rd_pin` is high). It is 0 when no read strobe is high.
- R3: On a rising edge with `wr_pin` high, each output-value bit whose `wdata` bit is 1 is inverted. Bits whose `wdata` bit is 0 keep their value.
- R4: On every rising edge with `tgl_ovr_en[i]` high, output-value bit i is inverted. This inversion is applied on top of any `wr_port` load or `wr_pin` toggle in the same cycle.
- R5: With `pu_ovr_en[i]` low, `pad_pu[i]` is 1 exactly when direction bit i is 0, output-value bit i is 1 and `pud` is 0.
- R6: With `pu_ovr_en[i]` high, `pad_pu[i]` equals `pu_ovr_val[i]`, whatever the register bits and `pud` hold.
- R7: `pad_oe[i]` equals `dir_ovr_val[i]` when `dir_ovr_en[i]` is high. Otherwise it equals direction bit i.
- R8: While `pad_oe[i]` is 1, `pad_out[i]` equals `val_ovr_val[i]` if `val_ovr_en[i]` is high, and output-value bit i otherwise. While `pad_oe[i]` is 0, `pad_out[i]` is 0.
- R9: The input enable of pin i is `ie_ovr_val[i]` when `ie_ovr_en[i]` is high, and the inverse of `sleep` otherwise. `din_raw[i]` is `pad_in[i]` ANDed with that enable, so it is 0 while the input is disabled.
- R10: The pin register takes `din_raw` through a falling-edge stage and then a rising-edge stage. A value present before a falling edge becomes readable after the next rising edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_dir | input | 1 | Load direction register from `wdata` |
| wr_port | input | 1 | Load output-value register from `wdata` |
| wr_pin | input | 1 | Invert output-value bits where `wdata` is 1 |
| wdata | input | NPIN | Write data |
| rd_dir | input | 1 | Select direction register onto `rdata` |
| rd_port | input | 1 | Select output-value register onto `rdata` |
| rd_pin | input | 1 | Select synchronized pin register onto `rdata` |
| rdata | output | NPIN | Read data |
| pud | input | 1 | Global pull-up disable |
| sleep | input | 1 | Global sleep; disables inputs that are not overridden |
| pu_ovr_en | input | NPIN | Pull-up override enable per pin |
| pu_ovr_val | input | NPIN | Pull-up override value per pin |
| dir_ovr_en | input | NPIN | Driver-enable override enable per pin |
| dir_ovr_val | input | NPIN | Driver-enable override value per pin |
| val_ovr_en | input | NPIN | Output-value override enable per pin |
| val_ovr_val | input | NPIN | Output-value override value per pin |
| tgl_ovr_en | input | NPIN | Per-pin invert of the output-value bit each clock |
| ie_ovr_en | input | NPIN | Input-enable override enable per pin |
| ie_ovr_val | input | NPIN | Input-enable override value per pin |
| pad_in | input | NPIN | Pad input level |
| pad_out | output | NPIN | Pad output value |
| pad_oe | output | NPIN | Pad output-driver enable |
| pad_pu | output | NPIN | Pad pull-up enable |
| din_raw | output | NPIN | Gated, unsynchronized input for peripherals |

## Verification
The bench builds the port with `NPIN = 4`. Four pins are enough to assign each pin a different override combination in the same vector. Every combination of the eleven per-pin bits is swept under all four settings of `pud` and `sleep`:
- direction and output-value bits;
- the four override enable/value pairs;
- the pad level.

This covers all 8192 joint cases of the pull-up, driver, value and input-enable multiplexers, and each case is also read back through the synchronizer. Directed sequences then cover the register toggles, the read-strobe OR, and the half-cycle boundary of the synchronizer.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    // One override channel: enable selects the value over the default path.
    typedef struct packed {
        logic en;
        logic val;
    } ovr_t;

    // Pull-up default path: input direction, output-value bit set, not disabled globally.
    function automatic logic pullup_default(input logic dir_b, input logic port_b, input logic pud_b);
        return (!dir_b) && port_b && (!pud_b);
    endfunction

    // Resolve an override channel against its default.
    function automatic logic resolve(input ovr_t o, input logic dflt);
        return o.en ? o.val : dflt;
    endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs #(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_dir,
    input  logic            wr_port,
    input  logic            wr_pin,
    input  logic [NPIN-1:0] wdata,
    input  logic [NPIN-1:0] tgl_ovr_en,
    output logic [NPIN-1:0] dir_q,
    output logic [NPIN-1:0] port_q
);
    logic [NPIN-1:0] port_base;
    logic [NPIN-1:0] port_flip;
    logic [NPIN-1:0] port_nxt;

    always_comb begin
        port_base = wr_port ? wdata : port_q;
        port_flip = (wr_pin ? wdata : '0) ^ tgl_ovr_en;
        port_nxt  = port_base ^ port_flip;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            port_q <= '0;
        end else begin
            if (wr_dir) dir_q <= wdata;
            port_q <= port_nxt;
        end
    end
endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl
    import gpio_pkg::*;
(
    input  logic dir_b,
    input  logic port_b,
    input  logic pud,
    input  logic sleep,
    input  ovr_t pu_ovr,
    input  ovr_t dir_ovr,
    input  ovr_t val_ovr,
    input  ovr_t ie_ovr,
    input  logic pad_in,
    output logic pad_out,
    output logic pad_oe,
    output logic pad_pu,
    output logic din_raw
);
    logic oe_w;
    logic ie_w;

    always_comb begin
        oe_w    = resolve(dir_ovr, dir_b);
        ie_w    = resolve(ie_ovr, !sleep);
        pad_oe  = oe_w;
        pad_out = oe_w & resolve(val_ovr, port_b);
        pad_pu  = resolve(pu_ovr, pullup_default(dir_b, port_b, pud));
        din_raw = pad_in & ie_w;
    end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] d,
    output logic [NPIN-1:0] q
);
    logic [NPIN-1:0] stage1;

    // First stage closes on the falling edge, second on the rising edge.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) stage1 <= '0;
        else        stage1 <= d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= stage1;
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_dir,
    input  logic            wr_port,
    input  logic            wr_pin,
    input  logic [NPIN-1:0] wdata,
    input  logic            rd_dir,
    input  logic            rd_port,
    input  logic            rd_pin,
    output logic [NPIN-1:0] rdata,
    input  logic            pud,
    input  logic            sleep,
    input  logic [NPIN-1:0] pu_ovr_en,
    input  logic [NPIN-1:0] pu_ovr_val,
    input  logic [NPIN-1:0] dir_ovr_en,
    input  logic [NPIN-1:0] dir_ovr_val,
    input  logic [NPIN-1:0] val_ovr_en,
    input  logic [NPIN-1:0] val_ovr_val,
    input  logic [NPIN-1:0] tgl_ovr_en,
    input  logic [NPIN-1:0] ie_ovr_en,
    input  logic [NPIN-1:0] ie_ovr_val,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe,
    output logic [NPIN-1:0] pad_pu,
    output logic [NPIN-1:0] din_raw
);
    logic [NPIN-1:0] dir_q;
    logic [NPIN-1:0] port_q;
    logic [NPIN-1:0] pin_q;

    gpio_regs #(.NPIN(NPIN)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_dir     (wr_dir),
        .wr_port    (wr_port),
        .wr_pin     (wr_pin),
        .wdata      (wdata),
        .tgl_ovr_en (tgl_ovr_en),
        .dir_q      (dir_q),
        .port_q     (port_q)
    );

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        gpio_pin_ctl u_ctl (
            .dir_b   (dir_q[i]),
            .port_b  (port_q[i]),
            .pud     (pud),
            .sleep   (sleep),
            .pu_ovr  ('{en: pu_ovr_en[i],  val: pu_ovr_val[i]}),
            .dir_ovr ('{en: dir_ovr_en[i], val: dir_ovr_val[i]}),
            .val_ovr ('{en: val_ovr_en[i], val: val_ovr_val[i]}),
            .ie_ovr  ('{en: ie_ovr_en[i],  val: ie_ovr_val[i]}),
            .pad_in  (pad_in[i]),
            .pad_out (pad_out[i]),
            .pad_oe  (pad_oe[i]),
            .pad_pu  (pad_pu[i]),
            .din_raw (din_raw[i])
        );
    end

    gpio_sync #(.NPIN(NPIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (din_raw),
        .q     (pin_q)
    );

    always_comb begin
        rdata = (rd_dir  ? dir_q  : '0)
              | (rd_port ? port_q : '0)
              | (rd_pin  ? pin_q  : '0);
    end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int NPIN = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_dir,
    input logic            wr_port,
    input logic            wr_pin,
    input logic [NPIN-1:0] wdata,
    input logic [NPIN-1:0] tgl_ovr_en,
    input logic [NPIN-1:0] dir_ovr_en,
    input logic [NPIN-1:0] dir_ovr_val,
    input logic [NPIN-1:0] pad_in,
    input logic [NPIN-1:0] pad_out,
    input logic [NPIN-1:0] pad_oe,
    input logic [NPIN-1:0] din_raw,
    input logic [NPIN-1:0] dir_q,
    input logic [NPIN-1:0] port_q,
    input logic [NPIN-1:0] pin_q
);
    logic [NPIN-1:0] fall_smp;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_smp <= '0;
        else        fall_smp <= din_raw;
    end

    // R1: registers held clear while reset is asserted
    always @(negedge clk) begin
        if (!rst_n) begin
            a_r1_reset_clear: assert (dir_q == '0 && port_q == '0 && pin_q == '0);
        end
    end

    a_r2_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> dir_q == $past(wdata));

    a_r3_pin_write_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pin && !wr_port && tgl_ovr_en == '0) |=> port_q == ($past(port_q) ^ $past(wdata)));

    a_r4_toggle_override: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_pin && !wr_port) |=> port_q == ($past(port_q) ^ $past(tgl_ovr_en)));

    a_r7_dir_override: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_ovr_en & (pad_oe ^ dir_ovr_val)) == '0);

    a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);

    a_r9_gated_input: assert property (@(posedge clk) disable iff (!rst_n)
        (din_raw & ~pad_in) == '0);

    a_r10_sync_path: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pin_q == $past(fall_smp));
endmodule

bind gpio_port gpio_port_chk #(.NPIN(NPIN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_dir      (wr_dir),
    .wr_port     (wr_port),
    .wr_pin      (wr_pin),
    .wdata       (wdata),
    .tgl_ovr_en  (tgl_ovr_en),
    .dir_ovr_en  (dir_ovr_en),
    .dir_ovr_val (dir_ovr_val),
    .pad_in      (pad_in),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .din_raw     (din_raw),
    .dir_q       (dir_q),
    .port_q      (port_q),
    .pin_q       (pin_q)
);

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_dir = 0, wr_port = 0, wr_pin = 0;
    logic rd_dir = 0, rd_port = 0, rd_pin = 0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic pud = 0, sleep = 0;
    logic [N-1:0] pu_ovr_en = '0, pu_ovr_val = '0, dir_ovr_en = '0, dir_ovr_val = '0;
    logic [N-1:0] val_ovr_en = '0, val_ovr_val = '0, tgl_ovr_en = '0;
    logic [N-1:0] ie_ovr_en = '0, ie_ovr_val = '0, pad_in = '0;
    logic [N-1:0] pad_out, pad_oe, pad_pu, din_raw;

    int nvec = 0;
    int nfail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_port #(.NPIN(N)) u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_dir(wr_dir), .wr_port(wr_port), .wr_pin(wr_pin), .wdata(wdata),
        .rd_dir(rd_dir), .rd_port(rd_port), .rd_pin(rd_pin), .rdata(rdata),
        .pud(pud), .sleep(sleep),
        .pu_ovr_en(pu_ovr_en), .pu_ovr_val(pu_ovr_val),
        .dir_ovr_en(dir_ovr_en), .dir_ovr_val(dir_ovr_val),
        .val_ovr_en(val_ovr_en), .val_ovr_val(val_ovr_val),
        .tgl_ovr_en(tgl_ovr_en),
        .ie_ovr_en(ie_ovr_en), .ie_ovr_val(ie_ovr_val),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pu(pad_pu), .din_raw(din_raw)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Advance to just after the next rising edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic read_reg(input int sel, output logic [N-1:0] v);
        rd_dir = (sel == 0); rd_port = (sel == 1); rd_pin = (sel == 2);
        #0.5;
        v = rdata;
        rd_dir = 0; rd_port = 0; rd_pin = 0;
    endtask

    task automatic write_reg(input int sel, input logic [N-1:0] v);
        wdata = v;
        wr_dir = (sel == 0); wr_port = (sel == 1); wr_pin = (sel == 2);
        tick();
        wr_dir = 0; wr_port = 0; wr_pin = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] v;
        logic [N-1:0] dv, pv, pe, pvl, de, dvl, ve, vvl, ie, ivl, pin;
        logic [N-1:0] e_oe, e_out, e_pu, e_din;

        // R1: reset state, with pad high and input enabled
        pad_in = '1;
        repeat (3) @(negedge clk);
        rd_dir = 1; rd_port = 1; rd_pin = 1;
        #0.5;
        check("R1 regs in reset", rdata, '0);
        check("R1 oe in reset", pad_oe, '0);
        check("R1 pu in reset", pad_pu, '0);
        rd_dir = 0; rd_port = 0; rd_pin = 0;
        pad_in = '0;
        @(negedge clk);
        rst_n = 1;
        tick();

        // R2: loads and read-strobe OR
        write_reg(0, 4'b1010);
        read_reg(0, v); check("R2 dir load", v, 4'b1010);
        #0.5; check("R2 no strobe reads 0", rdata, '0);
        write_reg(1, 4'b0101);
        rd_dir = 1; rd_port = 1; #0.5;
        check("R2 OR of dir and port", rdata, 4'b1111);
        rd_dir = 0; rd_port = 0;

        // R3: pin-register write toggles ones only
        write_reg(2, 4'b0011);
        read_reg(1, v); check("R3 toggle by ones", v, 4'b0110);
        write_reg(2, 4'b0000);
        read_reg(1, v); check("R3 zeros have no effect", v, 4'b0110);

        // R4: toggle override inverts each clock, stacks with a port load
        tgl_ovr_en = 4'b1001;
        tick();
        tgl_ovr_en = '0;
        read_reg(1, v); check("R4 one toggle cycle", v, 4'b1111);
        tgl_ovr_en = 4'b0011;
        tick(); tick();
        tgl_ovr_en = '0;
        read_reg(1, v); check("R4 two toggle cycles", v, 4'b1111);
        tgl_ovr_en = 4'b0100;
        write_reg(1, 4'b0001);
        tgl_ovr_en = '0;
        read_reg(1, v); check("R4 with port load", v, 4'b0101);

        // R10: synchronizer boundary (inputs driven 1 ns after a rising edge)
        write_reg(0, '0);
        pad_in = 4'b1011;
        #0.5;
        check("R9 raw input passes", din_raw, 4'b1011);
        read_reg(2, v); check("R10 not visible before edge", v, 4'b0000);
        tick();
        read_reg(2, v); check("R10 visible after edge", v, 4'b1011);
        sleep = 1;
        #0.5; check("R9 sleep gates raw input", din_raw, '0);
        tick();
        read_reg(2, v); check("R9 sleep reads 0", v, '0);
        sleep = 0;

        // Sweep: 11 per-pin bits, each pin offset, all pud/sleep settings
        for (int g = 0; g < 4; g++) begin
            for (int c = 0; c < 2048; c++) begin
                for (int i = 0; i < N; i++) begin
                    automatic logic [10:0] b = 11'((c + i * 517) & 2047);
                    dv[i] = b[0]; pv[i] = b[1]; pe[i] = b[2]; pvl[i] = b[3];
                    de[i] = b[4]; dvl[i] = b[5]; ve[i] = b[6]; vvl[i] = b[7];
                    ie[i] = b[8]; ivl[i] = b[9]; pin[i] = b[10];
                end
                write_reg(0, dv);
                write_reg(1, pv);
                pud = g[0]; sleep = g[1];
                pu_ovr_en = pe; pu_ovr_val = pvl;
                dir_ovr_en = de; dir_ovr_val = dvl;
                val_ovr_en = ve; val_ovr_val = vvl;
                ie_ovr_en = ie; ie_ovr_val = ivl;
                pad_in = pin;
                #0.5;
                e_oe  = (de & dvl) | (~de & dv);
                e_out = e_oe & ((ve & vvl) | (~ve & pv));
                e_pu  = (pe & pvl) | (~pe & ~dv & pv & {N{~g[0]}});
                e_din = pin & ((ie & ivl) | (~ie & {N{~g[1]}}));
                check("R7 pad_oe sweep", pad_oe, e_oe);
                check("R8 pad_out sweep", pad_out, e_out);
                check(pe == '0 ? "R5 pull-up sweep" : "R6 pull-up sweep", pad_pu, e_pu);
                check("R9 din_raw sweep", din_raw, e_din);
                tick();
                read_reg(2, v); check("R10 pin sweep", v, e_din);
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule